// File: doc/BRIEF.md
# Configuration Header Register File for a Single-Function Bus Target

This block holds the 256-byte type-0 configuration header of a single-function target on a parallel local bus. The bus front end decodes the transaction and presents one access at a time. Each access has a valid strobe, a write flag, a dword index, four byte enables and 32 bits of write data. Read data returns registered, one cycle after the strobe. Three event inputs from the transaction logic set sticky status flags, and software clears each flag by writing a 1 to it.

The block sends the three writable command controls and the programmed memory window base to the rest of the target. It also compares an incoming address page against the window, which gives a memory-hit signal. The identity words, the class code, the header layout byte and the DEVSEL timing field are constants. Every register that is not implemented reads as zero and ignores writes. The memory window is 256 bytes and supports sizing: after all ones are written, the register returns a mask with the low eight bits clear.

Top module: `cfg_space_hdr`

## Requirements
- R1: During and after reset, all three command controls are 0, all three status flags are 0, the window base is 0, and `acc_rdata` is 0.
- R2: A read of dword index 0 returns the device identifier (parameter `DEVICE_ID`) in bits 31:16 and the constant 0x1022 in bits 15:0.
- R3: In dword 1, only command bits 1 (memory enable, bit 1), 6 (parity response, bit 6) and 8 (error-line enable, bit 8) can be written. The outputs `ctl_mem_en`, `ctl_perr_rsp` and `ctl_serr_en` follow these bits. All other command bits read as 0.
- R4: Dword 1 bits 26:25 (status bits 10:9, the DEVSEL timing) always read as 01, which is medium timing. The encoding is 00 fast, 01 medium, 10 slow, 11 reserved. Writes cannot change these bits.
- R5: A one-cycle pulse on `evt_tabort`, `evt_serr` or `evt_perr` sets dword 1 bit 27, bit 30 or bit 31 (status bits 11, 14, 15), and the bit stays set.
- R6: A status flag clears only when a write to dword 1 has byte enable 3 set and a 1 in that flag's bit position. Writing a 0 has no effect. When an event pulse and a clear reach the same flag in the same cycle, the flag stays set.
- R7: Dword 4 is a memory window of 256 bytes, and its bits 7:0 always read 0 (bit 0 = 0 marks memory space). Writing 0xFFFFFFFF reads back 0xFFFFFF00, and writing 0xCD000000 reads back 0xCD000000.
- R8: Dword 2 reads as class code 0x018000 (mass-storage controller) in bits 31:8 and the revision parameter (default 0x00) in bits 7:0.
- R9: Dword 3 reads as 0x00000000. The header layout byte (bits 23:16) is 0x00, which means layout type 0 and single function.
- R10: A write changes only the bytes whose byte enable is 1. Byte `b` covers bits 8b+7:8b.
- R11: Writes to dwords 0, 2, 3 and to every index from 5 to 63 are ignored. Indices 5 to 63 read as zero.
- R12: `mem_hit` is 1 exactly when `ctl_mem_en` is 1 and `hit_page` (address bits 31:8) equals the window base.
- R13: `acc_rdata` loads the selected dword at the clock edge where a read strobe is sampled. It holds its value across idle cycles and across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Configuration access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 6 | Dword index into the 256-byte header |
| acc_be | input | 4 | Byte enables, active high |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| evt_tabort | input | 1 | Target-abort event pulse |
| evt_serr | input | 1 | System-error event pulse |
| evt_perr | input | 1 | Parity-error event pulse |
| hit_page | input | 24 | Bus address bits 31:8 for the window compare |
| mem_hit | output | 1 | Address falls in the enabled memory window |
| ctl_mem_en | output | 1 | Memory space enable |
| ctl_perr_rsp | output | 1 | Parity error response enable |
| ctl_serr_en | output | 1 | System-error line driver enable |
| bar_base | output | 24 | Programmed window base, address bits 31:8 |

## Verification
The assertions assume that every access is a single-cycle strobe with known values on index, byte enables and write data. They also assume that event inputs are known after reset, and that a register can change only through its own write decode or an event. The bench drives every input at the falling clock edge. It raises `acc_vld` for exactly one cycle per access and keeps event pulses to one cycle. It samples `acc_rdata` one full cycle after each read strobe, so each access completes before the next one is driven.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int DW     = 32;
  localparam int NBYTES = DW / 8;

  localparam logic [15:0] VENDOR_CODE   = 16'h1022;
  localparam logic [23:0] CLASS_CODE    = 24'h018000;
  localparam logic [7:0]  HDR_LAYOUT    = 8'h00;
  localparam logic [1:0]  DEVSEL_MEDIUM = 2'b01;

  // dword bit positions (status bits sit in the upper half-word)
  localparam int CMD_MEM_BIT   = 1;
  localparam int CMD_PERR_BIT  = 6;
  localparam int CMD_SERR_BIT  = 8;
  localparam int STS_TABORT_BIT = 16 + 11;
  localparam int STS_SERR_BIT   = 16 + 14;
  localparam int STS_PERR_BIT   = 16 + 15;

  typedef enum logic [2:0] {
    SEL_ID     = 3'd0,
    SEL_CMDSTS = 3'd1,
    SEL_CLASS  = 3'd2,
    SEL_MISC   = 3'd3,
    SEL_BAR    = 3'd4,
    SEL_NONE   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/cfg_acc_decode.sv
module cfg_acc_decode
  import cfg_hdr_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic [IDX_W-1:0] acc_idx,
  output reg_sel_e         sel,
  output logic             wr_cmdsts,
  output logic             wr_bar,
  output logic             rd_stb
);
  always_comb begin
    case (acc_idx)
      IDX_W'(0): sel = SEL_ID;
      IDX_W'(1): sel = SEL_CMDSTS;
      IDX_W'(2): sel = SEL_CLASS;
      IDX_W'(3): sel = SEL_MISC;
      IDX_W'(4): sel = SEL_BAR;
      default:   sel = SEL_NONE;
    endcase
  end

  assign wr_cmdsts = acc_vld && acc_wr && (sel == SEL_CMDSTS);
  assign wr_bar    = acc_vld && acc_wr && (sel == SEL_BAR);
  assign rd_stb    = acc_vld && !acc_wr;
endmodule

// File: rtl/cfg_cmd_stat.sv
module cfg_cmd_stat
  import cfg_hdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [2:0]  cmd_bits,   // {serr_en, perr_rsp, mem_en} write values
  input  logic [2:0]  clr_bits,   // {perr, serr, tabort} write-one-clear values
  input  logic        evt_tabort,
  input  logic        evt_serr,
  input  logic        evt_perr,
  output logic        cmd_mem,
  output logic        cmd_perr,
  output logic        cmd_serr,
  output logic        st_tabort,
  output logic        st_serr,
  output logic        st_perr,
  output logic [31:0] word
);
  logic mem_d, perr_d, serr_d;
  logic tab_d, sse_d, dpe_d;
  logic clr_en;

  assign clr_en = wr_en && be[3];

  always_comb begin
    mem_d  = cmd_mem;
    perr_d = cmd_perr;
    serr_d = cmd_serr;
    if (wr_en && be[0]) begin
      mem_d  = cmd_bits[0];
      perr_d = cmd_bits[1];
    end
    if (wr_en && be[1]) begin
      serr_d = cmd_bits[2];
    end
  end

  // an event in the same cycle as a clear wins
  always_comb begin
    tab_d = evt_tabort | (st_tabort & ~(clr_en & clr_bits[0]));
    sse_d = evt_serr   | (st_serr   & ~(clr_en & clr_bits[1]));
    dpe_d = evt_perr   | (st_perr   & ~(clr_en & clr_bits[2]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_mem   <= 1'b0;
      cmd_perr  <= 1'b0;
      cmd_serr  <= 1'b0;
      st_tabort <= 1'b0;
      st_serr   <= 1'b0;
      st_perr   <= 1'b0;
    end else begin
      cmd_mem   <= mem_d;
      cmd_perr  <= perr_d;
      cmd_serr  <= serr_d;
      st_tabort <= tab_d;
      st_serr   <= sse_d;
      st_perr   <= dpe_d;
    end
  end

  always_comb begin
    word                 = '0;
    word[CMD_MEM_BIT]    = cmd_mem;
    word[CMD_PERR_BIT]   = cmd_perr;
    word[CMD_SERR_BIT]   = cmd_serr;
    word[26:25]          = DEVSEL_MEDIUM;
    word[STS_TABORT_BIT] = st_tabort;
    word[STS_SERR_BIT]   = st_serr;
    word[STS_PERR_BIT]   = st_perr;
  end
endmodule

// File: rtl/cfg_bar_reg.sv
module cfg_bar_reg
  import cfg_hdr_pkg::*;
#(
  parameter int BAR_LSB = 8,
  localparam int PAGE_W = DW - BAR_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NBYTES-1:0] be,
  input  logic [DW-1:0]     wdata,
  input  logic              mem_en,
  input  logic [PAGE_W-1:0] page,
  output logic [PAGE_W-1:0] base,
  output logic [DW-1:0]     word,
  output logic              hit
);
  logic [DW-1:0]     cur;
  logic [DW-1:0]     merged;
  logic [PAGE_W-1:0] base_d;

  assign cur = {base, {BAR_LSB{1'b0}}};

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_comb begin
      merged[b*8 +: 8] = (wr_en && be[b]) ? wdata[b*8 +: 8] : cur[b*8 +: 8];
    end
  end

  assign base_d = merged[DW-1:BAR_LSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
    end else begin
      base <= base_d;
    end
  end

  // low bits read zero: memory space, not prefetchable, size mask
  assign word = cur;
  assign hit  = mem_en && (page == base);

  logic unused_low;
  assign unused_low = ^merged[BAR_LSB-1:0];
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] DEVICE_ID = 16'h5A31,
  parameter logic [7:0]  REVISION  = 8'h00
) (
  input  reg_sel_e      sel,
  input  logic [DW-1:0] cmdsts_word,
  input  logic [DW-1:0] bar_word,
  output logic [DW-1:0] rd_word
);
  always_comb begin
    case (sel)
      SEL_ID:     rd_word = {DEVICE_ID, VENDOR_CODE};
      SEL_CMDSTS: rd_word = cmdsts_word;
      SEL_CLASS:  rd_word = {CLASS_CODE, REVISION};
      SEL_MISC:   rd_word = {8'h00, HDR_LAYOUT, 16'h0000};
      SEL_BAR:    rd_word = bar_word;
      default:    rd_word = '0;
    endcase
  end
endmodule

// File: rtl/cfg_space_hdr.sv
module cfg_space_hdr
  import cfg_hdr_pkg::*;
#(
  parameter int          CFG_BYTES = 256,
  parameter int          BAR_LSB   = 8,
  parameter logic [15:0] DEVICE_ID = 16'h5A31,
  parameter logic [7:0]  REVISION  = 8'h00,
  localparam int         IDX_W     = $clog2(CFG_BYTES / 4),
  localparam int         PAGE_W    = DW - BAR_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [NBYTES-1:0] acc_be,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     acc_rdata,
  input  logic              evt_tabort,
  input  logic              evt_serr,
  input  logic              evt_perr,
  input  logic [PAGE_W-1:0] hit_page,
  output logic              mem_hit,
  output logic              ctl_mem_en,
  output logic              ctl_perr_rsp,
  output logic              ctl_serr_en,
  output logic [PAGE_W-1:0] bar_base
);
  reg_sel_e      sel;
  logic          wr_cmdsts, wr_bar, rd_stb;
  logic          st_tabort, st_serr, st_perr;
  logic [DW-1:0] cmdsts_word, bar_word, rd_word, rdata_d;

  cfg_acc_decode #(.IDX_W(IDX_W)) u_dec (
    .acc_vld   (acc_vld),
    .acc_wr    (acc_wr),
    .acc_idx   (acc_idx),
    .sel       (sel),
    .wr_cmdsts (wr_cmdsts),
    .wr_bar    (wr_bar),
    .rd_stb    (rd_stb)
  );

  cfg_cmd_stat u_cs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_cmdsts),
    .be         (acc_be),
    .cmd_bits   ({acc_wdata[CMD_SERR_BIT], acc_wdata[CMD_PERR_BIT], acc_wdata[CMD_MEM_BIT]}),
    .clr_bits   ({acc_wdata[STS_PERR_BIT], acc_wdata[STS_SERR_BIT], acc_wdata[STS_TABORT_BIT]}),
    .evt_tabort (evt_tabort),
    .evt_serr   (evt_serr),
    .evt_perr   (evt_perr),
    .cmd_mem    (ctl_mem_en),
    .cmd_perr   (ctl_perr_rsp),
    .cmd_serr   (ctl_serr_en),
    .st_tabort  (st_tabort),
    .st_serr    (st_serr),
    .st_perr    (st_perr),
    .word       (cmdsts_word)
  );

  cfg_bar_reg #(.BAR_LSB(BAR_LSB)) u_bar (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_bar),
    .be     (acc_be),
    .wdata  (acc_wdata),
    .mem_en (ctl_mem_en),
    .page   (hit_page),
    .base   (bar_base),
    .word   (bar_word),
    .hit    (mem_hit)
  );

  cfg_rd_mux #(.DEVICE_ID(DEVICE_ID), .REVISION(REVISION)) u_mux (
    .sel         (sel),
    .cmdsts_word (cmdsts_word),
    .bar_word    (bar_word),
    .rd_word     (rd_word)
  );

  always_comb begin
    rdata_d = acc_rdata;
    if (rd_stb) rdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_rdata <= '0;
    else        acc_rdata <= rdata_d;
  end
endmodule

// File: rtl/cfg_space_hdr_chk.sv
module cfg_space_hdr_chk #(
  parameter int IDX_W  = 6,
  parameter int PAGE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_vld,
  input logic              acc_wr,
  input logic [IDX_W-1:0]  acc_idx,
  input logic [3:0]        acc_be,
  input logic [31:0]       acc_wdata,
  input logic              evt_tabort,
  input logic              evt_serr,
  input logic              evt_perr,
  input logic              st_tabort,
  input logic              st_serr,
  input logic              st_perr,
  input logic [PAGE_W-1:0] hit_page,
  input logic              mem_hit,
  input logic              ctl_mem_en,
  input logic              ctl_perr_rsp,
  input logic              ctl_serr_en,
  input logic [PAGE_W-1:0] bar_base
);
  logic wr1, wr4, clr_ok;
  assign wr1    = acc_vld && acc_wr && (acc_idx == IDX_W'(1));
  assign wr4    = acc_vld && acc_wr && (acc_idx == IDX_W'(4));
  assign clr_ok = wr1 && acc_be[3];

  a_r5_tabort_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tabort |=> st_tabort);
  a_r5_serr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_serr |=> st_serr);
  a_r5_perr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_perr |=> st_perr);
  a_r6_tabort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tabort && !(clr_ok && acc_wdata[27])) |=> st_tabort);
  a_r6_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_perr && !(clr_ok && acc_wdata[31])) |=> st_perr);
  a_r3_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr1 |=> ($stable(ctl_mem_en) && $stable(ctl_perr_rsp) && $stable(ctl_serr_en)));
  a_r7_bar_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr4 |=> $stable(bar_base));
  a_r12_hit_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> ctl_mem_en);
  a_r12_hit_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> (hit_page == bar_base));
endmodule

bind cfg_space_hdr cfg_space_hdr_chk #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_vld      (acc_vld),
  .acc_wr       (acc_wr),
  .acc_idx      (acc_idx),
  .acc_be       (acc_be),
  .acc_wdata    (acc_wdata),
  .evt_tabort   (evt_tabort),
  .evt_serr     (evt_serr),
  .evt_perr     (evt_perr),
  .st_tabort    (st_tabort),
  .st_serr      (st_serr),
  .st_perr      (st_perr),
  .hit_page     (hit_page),
  .mem_hit      (mem_hit),
  .ctl_mem_en   (ctl_mem_en),
  .ctl_perr_rsp (ctl_perr_rsp),
  .ctl_serr_en  (ctl_serr_en),
  .bar_base     (bar_base)
);

// File: tb/cfg_space_hdr_bench.sv
module cfg_space_hdr_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DEV = 16'h5A31;

  logic        clk;
  logic        rst_n;
  logic        acc_vld, acc_wr;
  logic [5:0]  acc_idx;
  logic [3:0]  acc_be;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        evt_tabort, evt_serr, evt_perr;
  logic [23:0] hit_page;
  logic        mem_hit, ctl_mem_en, ctl_perr_rsp, ctl_serr_en;
  logic [23:0] bar_base;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  cfg_space_hdr #(.DEVICE_ID(DEV)) u_cfg_space_hdr (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_idx(acc_idx), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .evt_tabort(evt_tabort), .evt_serr(evt_serr),
    .evt_perr(evt_perr), .hit_page(hit_page), .mem_hit(mem_hit),
    .ctl_mem_en(ctl_mem_en), .ctl_perr_rsp(ctl_perr_rsp),
    .ctl_serr_en(ctl_serr_en), .bar_base(bar_base)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = 1'b1; acc_idx = idx; acc_be = be; acc_wdata = d;
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic cfg_rd(input logic [5:0] idx, output logic [31:0] d);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = 1'b0; acc_idx = idx; acc_be = 4'hF;
    @(negedge clk);
    acc_vld = 1'b0;
    d = acc_rdata;
  endtask

  task automatic pulse(input logic t, input logic s, input logic p);
    @(negedge clk);
    evt_tabort = t; evt_serr = s; evt_perr = p;
    @(negedge clk);
    evt_tabort = 1'b0; evt_serr = 1'b0; evt_perr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    acc_vld = 0; acc_wr = 0; acc_idx = 0; acc_be = 0; acc_wdata = 0;
    evt_tabort = 0; evt_serr = 0; evt_perr = 0; hit_page = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", acc_rdata, 32'h0);
    check("R1 controls in reset", {29'h0, ctl_mem_en, ctl_perr_rsp, ctl_serr_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 base after reset", {8'h0, bar_base}, 32'h0);
    cfg_rd(6'd1, d); check("R1 cmd/status after reset", d, 32'h0200_0000);
    cfg_rd(6'd4, d); check("R1 window after reset", d, 32'h0);
  endtask

  task automatic t_identity();
    logic [31:0] d;
    cfg_rd(6'd0, d); check("R2 identity dword", d, {DEV, 16'h1022});
    cfg_rd(6'd2, d); check("R8 class/revision", d, 32'h0180_0000);
    cfg_rd(6'd3, d); check("R9 header layout", d, 32'h0);
  endtask

  task automatic t_command();
    logic [31:0] d;
    cfg_wr(6'd1, 4'b0011, 32'hFFFF_FFFF);
    cfg_rd(6'd1, d); check("R3 only bits 1,6,8 stick", d, 32'h0200_0142);
    check("R3 control outputs", {29'h0, ctl_mem_en, ctl_perr_rsp, ctl_serr_en}, 32'h7);
    cfg_wr(6'd1, 4'b0001, 32'h0);
    cfg_rd(6'd1, d); check("R10 byte 1 untouched", d, 32'h0200_0100);
    cfg_wr(6'd1, 4'b1100, 32'hFFFF_0000);
    cfg_rd(6'd1, d); check("R4 timing field fixed", d, 32'h0200_0100);
  endtask

  task automatic t_status();
    logic [31:0] d;
    pulse(1, 0, 0);
    cfg_rd(6'd1, d); check("R5 abort flag set", d, 32'h0A00_0100);
    pulse(0, 1, 1);
    repeat (3) @(negedge clk);
    cfg_rd(6'd1, d); check("R5 flags sticky", d, 32'hCA00_0100);
    cfg_wr(6'd1, 4'b1000, 32'h0000_0000);
    cfg_rd(6'd1, d); check("R6 zero write keeps flags", d, 32'hCA00_0100);
    cfg_wr(6'd1, 4'b1000, 32'h0800_0000);
    cfg_rd(6'd1, d); check("R6 clear abort only", d, 32'hC200_0100);
    cfg_wr(6'd1, 4'b0111, 32'hC000_0000);
    cfg_rd(6'd1, d); check("R10 clear needs byte 3", d, 32'hC200_0000);
    @(negedge clk);
    acc_vld = 1; acc_wr = 1; acc_idx = 6'd1; acc_be = 4'b1000; acc_wdata = 32'hC000_0000;
    evt_perr = 1;
    @(negedge clk);
    acc_vld = 0; acc_wr = 0; evt_perr = 0;
    cfg_rd(6'd1, d); check("R6 event beats clear", d, 32'h8200_0000);
  endtask

  task automatic t_window();
    logic [31:0] d;
    cfg_wr(6'd4, 4'hF, 32'hFFFF_FFFF);
    cfg_rd(6'd4, d); check("R7 sizing mask", d, 32'hFFFF_FF00);
    cfg_wr(6'd4, 4'hF, 32'hCD00_0000);
    cfg_rd(6'd4, d); check("R7 base readback", d, 32'hCD00_0000);
    cfg_wr(6'd4, 4'b0100, 32'h12AB_3456);
    cfg_rd(6'd4, d); check("R10 window byte 2", d, 32'hCDAB_0000);
  endtask

  task automatic t_hit();
    cfg_wr(6'd1, 4'b0001, 32'h0000_0002);
    hit_page = 24'hCDAB00;
    @(negedge clk); check("R12 hit inside window", {31'h0, mem_hit}, 32'h1);
    hit_page = 24'hCDAC00;
    @(negedge clk); check("R12 miss outside window", {31'h0, mem_hit}, 32'h0);
    hit_page = 24'hCDAB00;
    cfg_wr(6'd1, 4'b0001, 32'h0);
    @(negedge clk); check("R12 no hit when disabled", {31'h0, mem_hit}, 32'h0);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    cfg_wr(6'd0, 4'hF, 32'hFFFF_FFFF);
    cfg_wr(6'd2, 4'hF, 32'hFFFF_FFFF);
    cfg_wr(6'd3, 4'hF, 32'hFFFF_FFFF);
    cfg_wr(6'd5, 4'hF, 32'hFFFF_FFFF);
    cfg_rd(6'd0, d); check("R11 identity unchanged", d, {DEV, 16'h1022});
    cfg_rd(6'd2, d); check("R11 class unchanged", d, 32'h0180_0000);
    cfg_rd(6'd3, d); check("R11 header unchanged", d, 32'h0);
    cfg_rd(6'd5, d); check("R11 index 5 zero", d, 32'h0);
    cfg_rd(6'd63, d); check("R11 index 63 zero", d, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    cfg_rd(6'd4, d);
    repeat (4) @(negedge clk);
    check("R13 holds while idle", acc_rdata, 32'hCDAB_0000);
    cfg_wr(6'd4, 4'hF, 32'h1100_0000);
    check("R13 holds across write", acc_rdata, 32'hCDAB_0000);
  endtask

  initial begin
    t_reset();
    t_identity();
    t_command();
    t_status();
    t_window();
    t_hit();
    t_unimpl();
    t_hold();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule